// File: doc/BRIEF.md
# Direction-Overloaded Command Register Front End

This block sits between a narrow host bus and the analog front end of a data-acquisition module. The host uses three active-low command strobes and one direction line. A write stores one of three control values: the local channel select, the global source select or the programmable-gain code. The block holds these values and drives them to the multiplexer and gain controls. A read returns one byte of the 12-bit conversion result, which comes from a converter sequencer outside this block.

Two of the strobes serve two purposes, chosen by direction. On strobe 0, a write sets the channel and a read returns the low result byte. On strobe 1, a write sets the source and a read returns the high result byte. The high byte carries the top four result bits in its low nibble. Its upper nibble is always ones, so software rebuilds the count as low + 256 × (high − 240).

The gain register has no meaningful value until the host writes it for the first time. A sticky flag tells downstream logic whether that write has happened. The byte bus is driven only while a matching read is in progress. Its tri-state control is brought out as an output-enable signal.

Top module: `acq_cmd_if`

## Requirements
- R1: After a synchronous reset, `chan_sel` = 0, `src_sel` = 0, `gain_code` = 0 and `gain_valid` = 0. `rdata_oe` is 0 whenever no read strobe is active.
- R2: At a rising clock edge where `stb0_n` = 0 and `rd_wr` = 0, `chan_sel` takes `wdata[2:0]`. It shows the new value after that edge. `wdata[7:3]` has no effect.
- R3: At a rising clock edge where `stb1_n` = 0 and `rd_wr` = 0, `src_sel` takes `wdata[3:0]`. Codes 1 to 10 name slots 1 to 10; codes 14 and 15 name the diagnostic ground and reference sources. The code is passed on unchanged.
- R4: At a rising clock edge where `stb2_n` = 0 and `rd_wr` = 0, `gain_code` takes `wdata[1:0]`, encoded as 0 = x1, 1 = x2, 2 = x5, 3 = x10.
- R5: `gain_valid` goes to 1 at the first gain write after reset. It stays at 1 until the next reset. Writes on the other strobes leave it unchanged.
- R6: A register keeps its value in any cycle without a write on its own strobe. Reads (`rd_wr` = 1) change no register.
- R7: While `rd_wr` = 1 and `stb0_n` = 0, `rdata` = `result[7:0]` and `rdata_oe` = 1, combinationally.
- R8: While `rd_wr` = 1, `stb1_n` = 0 and `stb0_n` = 1, `rdata` = {4'b1111, `result[11:8]`} and `rdata_oe` = 1. Low + 256 × (high − 240) then equals `result` for every value from 0 to 4095.
- R9: `rdata_oe` = 0 and `rdata` = 0 during writes, with no strobe, and during a read on `stb2_n` alone.
- R10: If both `stb0_n` and `stb1_n` are low during a read, the low result byte is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stb0_n | input | 1 | Strobe: channel write / low-byte read |
| stb1_n | input | 1 | Strobe: source write / high-byte read |
| stb2_n | input | 1 | Strobe: gain write |
| rd_wr | input | 1 | Direction, 1 = read, 0 = write |
| wdata | input | 8 | Write data from host |
| result | input | 12 | Conversion result from sequencer |
| rdata | output | 8 | Read data to host |
| rdata_oe | output | 1 | Read bus drive enable |
| chan_sel | output | 3 | Local channel select |
| src_sel | output | 4 | Global source select |
| gain_code | output | 2 | Gain code |
| gain_valid | output | 1 | Gain has been written since reset |

## Verification
A wrong register in this block appears at the select or gain outputs one clock after the faulty write edge. It also appears when a read or a write on another strobe wrongly changes a held value. The bench compares every output after every cycle against a model, so a corrupted value is caught within one cycle. The read path has no register in it, so a wrong byte choice, a missing ones nibble or a bad priority shows on `rdata` in the same cycle as the strobe.

// File: rtl/acq_cmd_pkg.sv
package acq_cmd_pkg;
    localparam int BUS_W  = 8;
    localparam int RES_W  = 12;
    localparam int CHAN_W = 3;
    localparam int SRC_W  = 4;
    localparam int GAIN_W = 2;
    localparam int HI_USED = RES_W - BUS_W;
    localparam int HI_PAD  = BUS_W - HI_USED;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic [SRC_W-1:0]  src;
        logic [GAIN_W-1:0] gain;
        logic              gain_valid;
    } cmd_regs_t;

    typedef struct packed {
        logic wr_chan;
        logic wr_src;
        logic wr_gain;
        logic rd_lo;
        logic rd_hi;
    } cmd_dec_t;

    function automatic logic [BUS_W-1:0] hi_byte(input logic [RES_W-1:0] r);
        return {{HI_PAD{1'b1}}, r[RES_W-1:BUS_W]};
    endfunction
endpackage

// File: rtl/acq_cmd_decode.sv
module acq_cmd_decode
    import acq_cmd_pkg::*;
(
    input  logic     stb0_n,
    input  logic     stb1_n,
    input  logic     stb2_n,
    input  logic     rd_wr,
    output cmd_dec_t dec
);
    always_comb begin
        dec.wr_chan = !stb0_n && !rd_wr;
        dec.wr_src  = !stb1_n && !rd_wr;
        dec.wr_gain = !stb2_n && !rd_wr;
        dec.rd_lo   = !stb0_n && rd_wr;
        dec.rd_hi   = !stb1_n && rd_wr && stb0_n;
    end
endmodule

// File: rtl/acq_cmd_regs.sv
module acq_cmd_regs
    import acq_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cmd_dec_t         dec,
    input  logic [BUS_W-1:0] wdata,
    output cmd_regs_t        regs
);
    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else begin
            if (dec.wr_chan) regs.chan <= wdata[CHAN_W-1:0];
            if (dec.wr_src)  regs.src  <= wdata[SRC_W-1:0];
            if (dec.wr_gain) begin
                regs.gain       <= wdata[GAIN_W-1:0];
                regs.gain_valid <= 1'b1;
            end
        end
    end

    a_r5_valid_sticky: assert property (@(posedge clk) disable iff (rst)
        regs.gain_valid |=> regs.gain_valid);
    a_r4_gain_capture: assert property (@(posedge clk) disable iff (rst)
        dec.wr_gain |=> regs.gain == $past(wdata[GAIN_W-1:0]));
endmodule

// File: rtl/acq_readback.sv
module acq_readback
    import acq_cmd_pkg::*;
(
    input  cmd_dec_t         dec,
    input  logic [RES_W-1:0] result,
    output logic [BUS_W-1:0] rdata,
    output logic             rdata_oe
);
    always_comb begin
        rdata    = '0;
        rdata_oe = dec.rd_lo || dec.rd_hi;
        if (dec.rd_lo)      rdata = result[BUS_W-1:0];
        else if (dec.rd_hi) rdata = hi_byte(result);
    end

    always_comb begin
        if (dec.rd_hi) a_r8_pad_ones: assert (rdata[BUS_W-1:HI_USED] == '1);
        if (!rdata_oe) a_r9_idle_zero: assert (rdata == '0);
    end
endmodule

// File: rtl/acq_cmd_if.sv
module acq_cmd_if
    import acq_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stb0_n,
    input  logic              stb1_n,
    input  logic              stb2_n,
    input  logic              rd_wr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [RES_W-1:0]  result,
    output logic [BUS_W-1:0]  rdata,
    output logic              rdata_oe,
    output logic [CHAN_W-1:0] chan_sel,
    output logic [SRC_W-1:0]  src_sel,
    output logic [GAIN_W-1:0] gain_code,
    output logic              gain_valid
);
    cmd_dec_t  dec;
    cmd_regs_t regs;

    acq_cmd_decode u_dec (
        .stb0_n(stb0_n), .stb1_n(stb1_n), .stb2_n(stb2_n),
        .rd_wr(rd_wr), .dec(dec)
    );

    acq_cmd_regs u_regs (
        .clk(clk), .rst(rst), .dec(dec), .wdata(wdata), .regs(regs)
    );

    acq_readback u_rb (
        .dec(dec), .result(result), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    assign chan_sel   = regs.chan;
    assign src_sel    = regs.src;
    assign gain_code  = regs.gain;
    assign gain_valid = regs.gain_valid;

    a_r2_chan_capture: assert property (@(posedge clk) disable iff (rst)
        (!stb0_n && !rd_wr) |=> chan_sel == $past(wdata[CHAN_W-1:0]));
    a_r3_src_capture: assert property (@(posedge clk) disable iff (rst)
        (!stb1_n && !rd_wr) |=> src_sel == $past(wdata[SRC_W-1:0]));
    a_r6_chan_hold: assert property (@(posedge clk) disable iff (rst)
        !(!stb0_n && !rd_wr) |=> $stable(chan_sel));
    a_r6_src_hold: assert property (@(posedge clk) disable iff (rst)
        !(!stb1_n && !rd_wr) |=> $stable(src_sel));
    a_r9_no_drive_on_write: assert property (@(posedge clk) disable iff (rst)
        !rd_wr |-> !rdata_oe);
    a_r10_low_wins: assert property (@(posedge clk) disable iff (rst)
        (rd_wr && !stb0_n && !stb1_n) |-> rdata == result[BUS_W-1:0]);
endmodule

// File: tb/sim_acq_cmd_if.sv
`timescale 1ns/1ps
module sim_acq_cmd_if;
    logic        clk = 0;
    logic        rst = 1;
    logic        s0 = 1, s1 = 1, s2 = 1, rw = 1;
    logic [7:0]  wdata = 0;
    logic [11:0] result = 0;
    logic [7:0]  rdata;
    logic        oe;
    logic [2:0]  chan;
    logic [3:0]  src;
    logic [1:0]  gain;
    logic        gv;

    int checks = 0, errors = 0;
    logic [2:0] m_chan = 0;
    logic [3:0] m_src = 0;
    logic [1:0] m_gain = 0;
    logic       m_gv = 0;

    always #2 clk = ~clk;

    acq_cmd_if u0 (
        .clk(clk), .rst(rst), .stb0_n(s0), .stb1_n(s1), .stb2_n(s2),
        .rd_wr(rw), .wdata(wdata), .result(result), .rdata(rdata),
        .rdata_oe(oe), .chan_sel(chan), .src_sel(src), .gain_code(gain),
        .gain_valid(gv)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [8:0] exp_read(logic a_n, logic b_n, logic r, logic [11:0] res);
        if (r && !a_n) return {1'b1, res[7:0]};
        if (r && !b_n) return {1'b1, 4'hF, res[11:8]};
        return 9'h0;
    endfunction

    task automatic cycle(logic a_n, logic b_n, logic c_n, logic r, logic [7:0] d, logic [11:0] res);
        logic [8:0] e;
        @(negedge clk);
        s0 = a_n; s1 = b_n; s2 = c_n; rw = r; wdata = d; result = res;
        #1;
        e = exp_read(a_n, b_n, r, res);
        check("R7/R8/R9/R10 oe", int'(oe), int'(e[8]));
        check("R7/R8/R9/R10 rdata", int'(rdata), int'(e[7:0]));
        if (!r && !a_n) m_chan = d[2:0];
        if (!r && !b_n) m_src = d[3:0];
        if (!r && !c_n) begin m_gain = d[1:0]; m_gv = 1; end
        @(posedge clk); #1;
        check("R2/R6 chan", int'(chan), int'(m_chan));
        check("R3/R6 src", int'(src), int'(m_src));
        check("R4/R6 gain", int'(gain), int'(m_gain));
        check("R5 gain_valid", int'(gv), int'(m_gv));
    endtask

    task automatic count_check(logic [11:0] v);
        int lo, hi;
        cycle(0, 1, 1, 1, 8'h00, v); lo = rdata;
        cycle(1, 0, 1, 1, 8'h00, v); hi = rdata;
        check("R8 rebuilt count", lo + 256 * (hi - 240), int'(v));
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(posedge clk);
        #1;
        check("R1 chan", int'(chan), 0);
        check("R1 src", int'(src), 0);
        check("R1 gain_valid", int'(gv), 0);
        check("R1 oe", int'(oe), 0);
        @(negedge clk); rst = 0;
        // R2: upper data bits ignored
        cycle(0, 1, 1, 0, 8'hFD, 12'h000);
        check("R2 chan from low bits", int'(chan), 5);
        // R5: other writes leave gain_valid clear
        cycle(1, 0, 1, 0, 8'h0E, 12'h000);
        check("R5 still invalid", int'(gv), 0);
        // R3: diagnostic and slot codes
        cycle(1, 0, 1, 0, 8'h0F, 12'h000);
        check("R3 src 15", int'(src), 15);
        cycle(1, 0, 1, 0, 8'h0A, 12'h000);
        // R4: each gain code
        for (int g = 0; g < 4; g++) cycle(1, 1, 0, 0, 8'(g) | 8'hFC, 12'h000);
        check("R4 gain x10 code", int'(gain), 3);
        // R9: read on strobe 2 alone, R6: reads leave registers
        cycle(1, 1, 0, 1, 8'h00, 12'hABC);
        check("R9 no drive on strobe 2 read", int'(oe), 0);
        // R10: both strobes in read
        cycle(0, 0, 1, 1, 8'h00, 12'h5A3);
        // R8: count rebuild at the ends and middle
        count_check(12'h000);
        count_check(12'hFFF);
        count_check(12'hA5C);
        // random mix
        for (int i = 0; i < 400; i++) begin
            cycle(($urandom % 3) != 0, ($urandom % 3) != 0, ($urandom % 3) != 0,
                  $urandom % 2, 8'($urandom), 12'($urandom));
        end
        // R1: reset again clears everything
        @(negedge clk); rst = 1; s0 = 1; s1 = 1; s2 = 1; rw = 1;
        @(posedge clk); #1;
        m_chan = 0; m_src = 0; m_gain = 0; m_gv = 0;
        check("R1 chan after reset", int'(chan), 0);
        check("R1 gain_valid after reset", int'(gv), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule